// File: doc/BRIEF.md
# Partial-Word Store Lane Generator

This block converts a partial-word store request into one big-endian memory write beat. A request carries a byte address, a data word and a span mode. In head mode the write covers the addressed byte and every later byte of the word. In tail mode it covers the bytes of the word that come before the addressed byte. The block returns the word-aligned address, a byte-enable mask and the write data with each byte in its memory lane. A flag marks a probe-only access. That flag is raised when a tail request sits on a word boundary: no byte is written, but a downstream memory stage must still check write permission for that address.

Every span, including a three-byte span, goes out as one beat, so a three-byte write is never split into two smaller accesses. Address translation, protection checking and cache-line dirty marking happen downstream. The outputs are registered and appear one clock after the request is accepted.

Top module: `bytestore_lane_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `wr_valid`, `wr_be`, `wr_probe`, `wr_addr` and `wr_data` are all zero.
- R2: A request that is accepted at a clock edge (`req_valid` = 1) produces `wr_valid` = 1 for exactly one cycle after that edge. If no request is accepted, `wr_valid` is 0 in the following cycle.
- R3: `wr_addr` equals the request address with its two low bits forced to zero.
- R4: Head mode (`req_tail` = 0) with offset k = `req_addr[1:0]` enables lanes k through 3. Lane 0 is the most significant byte. Bit j of `wr_be` enables `wr_data[8j+7:8j]`, so lane i corresponds to bit 3-i, and `wr_be` = 2^(4-k) - 1.
- R5: Tail mode (`req_tail` = 1) with offset k > 0 enables lanes 0 through k-1, so `wr_be` = 4'hF with its low 4-k bits cleared.
- R6: Tail mode with offset 0 gives `wr_be` = 0 and `wr_probe` = 1, and still presents the aligned address.
- R7: `wr_probe` is 1 exactly when `wr_be` is zero on a valid beat. Head mode never sets it.
- R8: A three-byte span (head offset 1 or tail offset 3) leaves as a single beat with exactly three enable bits set.
- R9: Each enabled lane carries the request data byte at that same bit position. Each disabled lane carries zero.
- R10: Requests on consecutive cycles each produce their own beat on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Byte address of the partial word |
| req_data | input | DATA_W | Store data word |
| req_tail | input | 1 | 0 = head span, 1 = tail span |
| wr_valid | output | 1 | Write beat valid |
| wr_addr | output | ADDR_W | Word-aligned write address |
| wr_be | output | DATA_W/8 | Byte enables, bit j for data bits 8j+7..8j |
| wr_data | output | DATA_W | Lane-aligned write data |
| wr_probe | output | 1 | Probe-only access, nothing is written |

## Verification
Every result (valid, address, enables, data and probe flag) is registered once, so all of them are due in the cycle after the edge that accepts the request. The bench drives inputs on the falling edge. On the next falling edge it compares the outputs with values it predicted from the previous cycle's inputs, so each check lands exactly one register stage after its stimulus. It sweeps both modes, every offset and several data patterns, both back to back and with idle gaps between requests. In the idle cycles it also checks that no stray beat appears.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
   typedef enum logic {
      SPAN_HEAD = 1'b0,
      SPAN_TAIL = 1'b1
   } span_mode_e;
endpackage

// File: rtl/bsl_addr_align.sv
module bsl_addr_align #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 2
) (
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_word,
   output logic [OFS_W-1:0]  byte_ofs
);
   always_comb begin
      byte_ofs  = addr_in[OFS_W-1:0];
      addr_word = {addr_in[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
   end
endmodule

// File: rtl/bsl_span_mask.sv
module bsl_span_mask
   import bsl_pkg::*;
#(
   parameter int NB    = 4,
   parameter int OFS_W = 2
) (
   input  logic [OFS_W-1:0] byte_ofs,
   input  span_mode_e       mode,
   output logic [NB-1:0]    lane_en,
   output logic             probe_only
);
   // lane i (0 = most significant byte) maps to enable bit NB-1-i
   for (genvar i = 0; i < NB; i++) begin : g_lane
      localparam logic [OFS_W-1:0] LANE_IDX = OFS_W'(i);
      logic after_ofs;
      always_comb begin
         after_ofs = (LANE_IDX >= byte_ofs);
         lane_en[NB-1-i] = (mode == SPAN_HEAD) ? after_ofs : !after_ofs;
      end
   end

   always_comb begin
      probe_only = (mode == SPAN_TAIL) && (byte_ofs == '0);
   end
endmodule

// File: rtl/bsl_lane_steer.sv
module bsl_lane_steer #(
   parameter int NB        = 4,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic [NB*8-1:0] data_in,
   input  logic [NB-1:0]   lane_en,
   output logic [NB*8-1:0] data_out
);
   // both spans keep bytes at their own bit positions; only idle lanes differ
   for (genvar j = 0; j < NB; j++) begin : g_byte
      if (ZERO_IDLE) begin : g_zero
         always_comb data_out[j*8 +: 8] = lane_en[j] ? data_in[j*8 +: 8] : 8'h00;
      end else begin : g_pass
         always_comb data_out[j*8 +: 8] = data_in[j*8 +: 8];
      end
   end
endmodule

// File: rtl/bytestore_lane_gen.sv
module bytestore_lane_gen
   import bsl_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_data,
   input  logic                req_tail,
   output logic                wr_valid,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [DATA_W/8-1:0] wr_be,
   output logic [DATA_W-1:0]   wr_data,
   output logic                wr_probe
);
   localparam int NB    = DATA_W / 8;
   localparam int OFS_W = (NB > 1) ? $clog2(NB) : 1;

   if (DATA_W % 8 != 0 || NB < 2 || (NB & (NB - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power-of-two number of bytes, at least two");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ADDR_W too small for the byte offset");
   end

   logic [ADDR_W-1:0] addr_word;
   logic [OFS_W-1:0]  byte_ofs;
   logic [NB-1:0]     lane_en;
   logic              probe_only;
   logic [DATA_W-1:0] data_lanes;
   span_mode_e        mode;

   assign mode = span_mode_e'(req_tail);

   bsl_addr_align #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_align (
      .addr_in   (req_addr),
      .addr_word (addr_word),
      .byte_ofs  (byte_ofs)
   );

   bsl_span_mask #(.NB(NB), .OFS_W(OFS_W)) u_mask (
      .byte_ofs   (byte_ofs),
      .mode       (mode),
      .lane_en    (lane_en),
      .probe_only (probe_only)
   );

   bsl_lane_steer #(.NB(NB), .ZERO_IDLE(ZERO_IDLE)) u_steer (
      .data_in  (req_data),
      .lane_en  (lane_en),
      .data_out (data_lanes)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_be    <= '0;
         wr_data  <= '0;
         wr_probe <= 1'b0;
      end else begin
         wr_valid <= req_valid;
         if (req_valid) begin
            wr_addr  <= addr_word;
            wr_be    <= lane_en;
            wr_data  <= data_lanes;
            wr_probe <= probe_only;
         end else begin
            wr_be    <= '0;
            wr_probe <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/bsl_checker.sv
module bsl_checker #(
   parameter int ADDR_W = 32,
   parameter int NB     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_tail,
   input logic [ADDR_W-1:0] req_addr,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [NB-1:0]     wr_be,
   input logic              wr_probe
);
   logic [NB-1:0] be_inv;
   logic          low_run;
   logic          high_run;
   always_comb begin
      be_inv   = ~wr_be;
      low_run  = (wr_be & (wr_be + {{(NB-1){1'b0}}, 1'b1})) == '0;
      high_run = (be_inv & (be_inv + {{(NB-1){1'b0}}, 1'b1})) == '0;
   end

   assert_beat_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> wr_valid);
   assert_no_stray_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !wr_valid);
   assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_addr[1:0] == 2'b00));
   assert_head_low_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_tail) |=> (low_run && wr_be[0] && !wr_probe));
   assert_tail_high_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_tail) |=> high_run);
   assert_tail_zero_probe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_tail && req_addr[1:0] == 2'b00) |=> wr_probe);
   assert_probe_iff_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_probe == (wr_be == '0)));
   assert_no_enable_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |-> ($countones(wr_be) == 0 && !wr_probe));
endmodule

bind bytestore_lane_gen bsl_checker #(.ADDR_W(ADDR_W), .NB(DATA_W/8)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_tail  (req_tail),
   .req_addr  (req_addr),
   .wr_valid  (wr_valid),
   .wr_addr   (wr_addr),
   .wr_be     (wr_be),
   .wr_probe  (wr_probe)
);

// File: tb/tb_bytestore_lane_gen.sv
module tb_bytestore_lane_gen;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_data;
   logic          req_tail;
   logic          wr_valid;
   logic [AW-1:0] wr_addr;
   logic [3:0]    wr_be;
   logic [DW-1:0] wr_data;
   logic          wr_probe;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic          e_valid = 1'b0;
   logic          prev_e_valid = 1'b0;
   logic [AW-1:0] e_addr;
   logic [3:0]    e_be;
   logic [DW-1:0] e_data;
   logic          e_probe;
   logic          e_tail;

   always #(CLK_PERIOD/2) clk = ~clk;

   bytestore_lane_gen dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_data(req_data), .req_tail(req_tail), .wr_valid(wr_valid),
      .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data), .wr_probe(wr_probe)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compare_outputs();
      if (e_valid) begin
         chk(wr_valid == 1'b1, prev_e_valid ? "R10 back-to-back beat" : "R2 beat due", 64'(wr_valid), 64'd1);
         chk(wr_addr == e_addr, "R3 aligned address", 64'(wr_addr), 64'(e_addr));
         if (e_probe)
            chk(wr_be == e_be, "R6 tail offset0 enables", 64'(wr_be), 64'(e_be));
         else if (e_tail)
            chk(wr_be == e_be, "R5 tail enables", 64'(wr_be), 64'(e_be));
         else
            chk(wr_be == e_be, "R4 head enables", 64'(wr_be), 64'(e_be));
         chk(wr_probe == e_probe, "R7 probe flag", 64'(wr_probe), 64'(e_probe));
         chk(wr_data == e_data, "R9 lane data", 64'(wr_data), 64'(e_data));
         if ($countones(e_be) == 3)
            chk($countones(wr_be) == 3, "R8 three-byte single beat", 64'($countones(wr_be)), 64'd3);
      end else begin
         chk(wr_valid == 1'b0, "R2 idle no beat", 64'(wr_valid), 64'd0);
      end
   endtask

   task automatic step(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic t);
      int k;
      @(negedge clk);
      compare_outputs();
      req_valid = v; req_addr = a; req_data = d; req_tail = t;
      prev_e_valid = e_valid;
      e_valid = v;
      k = int'(a[1:0]);
      e_addr = {a[AW-1:2], 2'b00};
      e_tail = t;
      if (!t) e_be = 4'((16 >> k) - 1);
      else    e_be = 4'(15 & ~((16 >> k) - 1));
      e_probe = t && (k == 0);
      for (int j = 0; j < 4; j++)
         e_data[j*8 +: 8] = e_be[j] ? d[j*8 +: 8] : 8'h00;
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0; req_tail = 1'b0;
      repeat (3) @(negedge clk);
      chk(wr_valid == 0 && wr_be == 0 && wr_probe == 0 && wr_addr == 0 && wr_data == 0,
          "R1 reset state", 64'({wr_valid, wr_be, wr_probe}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wr_valid == 0 && wr_be == 0 && wr_probe == 0, "R1 after reset", 64'({wr_valid, wr_be, wr_probe}), 64'd0);
      // back-to-back sweep
      for (int t = 0; t < 2; t++)
         for (int o = 0; o < 4; o++)
            for (int p = 0; p < 4; p++) begin
               logic [DW-1:0] d;
               d = (p == 0) ? 32'hA1B2C3D4 : (p == 1) ? 32'hFFFFFFFF :
                   (p == 2) ? 32'h01020304 : 32'h8000_0081 ^ (32'(o) << 12);
               step(1'b1, 32'h1000_0000 + 32'(p * 64) + 32'(o), d, t[0]);
            end
      // gapped sweep with high address bits
      for (int t = 0; t < 2; t++)
         for (int o = 0; o < 4; o++) begin
            step(1'b1, 32'hFFFF_FFF0 - 32'(t * 16) + 32'(o), 32'h5A6B7C8D + 32'(o), t[0]);
            step(1'b0, 32'h0000_0003, 32'hDEADBEEF, 1'b1);
         end
      step(1'b0, '0, '0, 1'b0);
      step(1'b0, '0, '0, 1'b0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule